// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block sits beside the two delayed-completion queues of a bridge, one queue per bus side. When a completion reaches the head of a side's queue, that side's timer begins counting clock cycles while it waits for the initiating master to return and retry the request. A retry stops the wait and leaves the entry in place. If the count reaches its limit first, the block issues a one-cycle discard strobe so the queue drops the stale entry.

Each side has its own select bit, which picks a long limit (2^LONG_EXP cycles) or a short limit (2^SHORT_EXP cycles). With the default parameters and a 33 MHz bus, these are about 1 ms and 31 us. Every discard on either side sets one shared sticky error flag, which software clears by writing a 1. A discard also raises a one-cycle system-error request, but only when the timeout error enable and the global error enable are both set. The select bits, the timeout error enable and the flag clear are all driven through one 4-bit configuration write port.

Top module: `dtt_discard_timer`

## Requirements
- R1: After synchronous reset, all outputs are 0, both select bits are 0 (long limit) and the timeout error enable is 0.
- R2: With its select bit at 0, the discard strobe goes high in the cycle after the 2^LONG_EXP-th rising edge that follows the edge at which an idle timer samples head-valid high. This holds provided head-valid stays high and no retry is sampled.
- R3: With its select bit at 1, the same timing applies with 2^SHORT_EXP in place of 2^LONG_EXP.
- R4: A retry sampled at any of the edges 1 to limit after the start edge cancels the wait and produces no discard, including a retry at the final edge. The timer then returns to idle.
- R5: If head-valid is sampled low while a timer is counting, the wait is abandoned and no discard follows.
- R6: A discard strobe lasts exactly one cycle. If head-valid is still high at the next edge, the timer restarts for the new head entry, so the second strobe comes limit+1 edges after the first.
- R7: The two sides count independently. On a write (cfg_wr_en high), cfg_wr_data bit 0 loads the primary select and bit 1 loads the secondary select.
- R8: The error flag is set at the edge where either discard strobe is high, so it is visible one cycle after the strobe. It stays set until it is cleared.
- R9: A write with cfg_wr_data bit 2 at 1 clears the error flag. If a discard strobe is high at the same edge, the set wins and the flag stays 1.
- R10: On a write, cfg_wr_data bit 3 loads the timeout error enable. serr_req is high in exactly the cycles where a discard strobe is high and both that enable and serr_global_en are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_head_valid | input | 1 | Primary queue has a delayed completion at its head |
| pri_retry | input | 1 | Primary master retried the head request (pulse) |
| sec_head_valid | input | 1 | Secondary queue has a delayed completion at its head |
| sec_retry | input | 1 | Secondary master retried the head request (pulse) |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 4 | Bit0 primary short select, bit1 secondary short select, bit2 flag clear, bit3 timeout error enable |
| serr_global_en | input | 1 | Global system-error enable |
| pri_discard | output | 1 | One-cycle discard of the primary head entry |
| sec_discard | output | 1 | One-cycle discard of the secondary head entry |
| to_status | output | 1 | Sticky discard-timeout flag |
| serr_req | output | 1 | System-error request pulse |

## Verification
Two functions can fall on the same edge. A discard can set the sticky flag while a configuration write tries to clear it, and a retry can arrive at the very edge where the count would expire. The bench creates the first case by writing the clear bit during the cycle in which the discard strobe is high, then expects the flag to read 1 on the following cycle. It creates the second case by placing the retry pulse on the limit-th edge, then expects no strobe and no flag.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    typedef enum logic {
        T_IDLE  = 1'b0,
        T_COUNT = 1'b1
    } tmr_state_t;

    typedef struct packed {
        logic serr_to_en;
        logic flag_clr;
        logic sel_sec;
        logic sel_pri;
    } cfg_word_t;

    localparam int NUM_SIDES = 2;

    function automatic logic [31:0] mask_of(input int unsigned e);
        return (32'd1 << e) - 32'd1;
    endfunction

endpackage

// File: rtl/dtt_cfg_regs.sv
module dtt_cfg_regs
    import dtt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  cfg_word_t            wr_data,
    output logic [NUM_SIDES-1:0] sel_short,
    output logic                 serr_to_en,
    output logic                 clr_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_short  <= '0;
            serr_to_en <= 1'b0;
        end else if (wr_en) begin
            sel_short  <= {wr_data.sel_sec, wr_data.sel_pri};
            serr_to_en <= wr_data.serr_to_en;
        end
    end

    assign clr_req = wr_en & wr_data.flag_clr;

    // R1: configuration is zero after reset
    assert_cfg_reset_R1: assert property (@(posedge clk)
        rst |=> (sel_short == '0 && !serr_to_en));

endmodule

// File: rtl/dtt_side_timer.sv
module dtt_side_timer
    import dtt_pkg::*;
#(
    parameter int unsigned LONG_EXP  = 15,
    parameter int unsigned SHORT_EXP = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic head_valid,
    input  logic retry_seen,
    input  logic sel_short,
    output logic discard
);
    localparam int unsigned CNT_W = LONG_EXP;

    tmr_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = sel_short ? CNT_W'(mask_of(SHORT_EXP)) : CNT_W'(mask_of(LONG_EXP));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= T_IDLE;
            cnt     <= '0;
            discard <= 1'b0;
        end else begin
            discard <= 1'b0;
            case (state)
                T_IDLE: begin
                    if (head_valid) begin
                        state <= T_COUNT;
                        cnt   <= '0;
                    end
                end
                T_COUNT: begin
                    if (!head_valid || retry_seen) begin
                        state <= T_IDLE;
                    end else if (cnt >= last) begin
                        discard <= 1'b1;
                        state   <= T_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= T_IDLE;
            endcase
        end
    end

    assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        discard |=> !discard);

    assert_retry_cancel_R4: assert property (@(posedge clk) disable iff (rst)
        retry_seen |=> !discard);

    assert_flush_R5: assert property (@(posedge clk) disable iff (rst)
        !head_valid |=> !discard);

endmodule

// File: rtl/dtt_err_status.sv
module dtt_err_status (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_evt)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

    assert_sets_R8: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_evt) |=> !flag);

endmodule

// File: rtl/dtt_discard_timer.sv
module dtt_discard_timer
    import dtt_pkg::*;
#(
    parameter int unsigned LONG_EXP  = 15,
    parameter int unsigned SHORT_EXP = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pri_head_valid,
    input  logic       pri_retry,
    input  logic       sec_head_valid,
    input  logic       sec_retry,
    input  logic       cfg_wr_en,
    input  logic [3:0] cfg_wr_data,
    input  logic       serr_global_en,
    output logic       pri_discard,
    output logic       sec_discard,
    output logic       to_status,
    output logic       serr_req
);
    logic [NUM_SIDES-1:0] hv, rt, sel_short, disc;
    logic                 serr_to_en;
    logic                 clr_req;
    cfg_word_t            cfg_word;

    assign hv       = {sec_head_valid, pri_head_valid};
    assign rt       = {sec_retry, pri_retry};
    assign cfg_word = cfg_word_t'(cfg_wr_data);

    dtt_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_word),
        .sel_short  (sel_short),
        .serr_to_en (serr_to_en),
        .clr_req    (clr_req)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dtt_side_timer #(
            .LONG_EXP  (LONG_EXP),
            .SHORT_EXP (SHORT_EXP)
        ) u_tmr (
            .clk        (clk),
            .rst        (rst),
            .head_valid (hv[s]),
            .retry_seen (rt[s]),
            .sel_short  (sel_short[s]),
            .discard    (disc[s])
        );
    end

    dtt_err_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_evt (|disc),
        .clr_req (clr_req),
        .flag    (to_status)
    );

    assign pri_discard = disc[0];
    assign sec_discard = disc[1];
    assign serr_req    = (|disc) & serr_to_en & serr_global_en;

    assert_serr_on_discard_R10: assert property (@(posedge clk) disable iff (rst)
        serr_req |-> (pri_discard || sec_discard) && serr_global_en);

    assert_serr_flags_R8: assert property (@(posedge clk) disable iff (rst)
        serr_req |=> to_status);

endmodule

// File: tb/test_dtt_discard_timer.sv
module test_dtt_discard_timer;
    localparam int LE     = 7;
    localparam int SE     = 4;
    localparam int L_LONG = 1 << LE;
    localparam int L_SHRT = 1 << SE;

    // {side, sel, err_en, glob_en, retry_at[7:0], exp_disc, exp_serr}
    localparam logic [13:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b1, 1'b1, 8'd0,   1'b1, 1'b1},
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd0,   1'b1, 1'b1},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd0,   1'b1, 1'b0},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'd0,   1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd5,   1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'd16,  1'b0, 1'b0},
        {1'b0, 1'b0, 1'b1, 1'b1, 8'd127, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'd0,   1'b1, 1'b1}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic pri_head_valid = 0, pri_retry = 0, sec_head_valid = 0, sec_retry = 0;
    logic cfg_wr_en = 0, serr_global_en = 0;
    logic [3:0] cfg_wr_data = '0;
    logic pri_discard, sec_discard, to_status, serr_req;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dtt_discard_timer #(.LONG_EXP(LE), .SHORT_EXP(SE)) i_dtt_discard_timer (
        .clk(clk), .rst(rst),
        .pri_head_valid(pri_head_valid), .pri_retry(pri_retry),
        .sec_head_valid(sec_head_valid), .sec_retry(sec_retry),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .serr_global_en(serr_global_en),
        .pri_discard(pri_discard), .sec_discard(sec_discard),
        .to_status(to_status), .serr_req(serr_req)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [3:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_data = '0;
    endtask

    task automatic set_hv(input int side, input logic v);
        if (side == 0) pri_head_valid = v; else sec_head_valid = v;
    endtask

    task automatic set_rt(input int side, input logic v);
        if (side == 0) pri_retry = v; else sec_retry = v;
    endtask

    task automatic run_side(input int side, input int retry_at, input int drop_at, input int nk,
                            output int first, output int last, output int nd,
                            output int no, output int ns);
        first = 0; last = 0; nd = 0; no = 0; ns = 0;
        @(negedge clk);
        set_hv(side, 1'b1);
        for (int k = 1; k <= nk; k++) begin
            @(negedge clk);
            if ((side == 0) ? pri_discard : sec_discard) begin
                nd++;
                if (first == 0) first = k;
                last = k;
            end
            if ((side == 0) ? sec_discard : pri_discard) no++;
            if (serr_req) ns++;
            if (k == retry_at) set_rt(side, 1'b1);
            else if (retry_at != 0 && k == retry_at + 1) begin
                set_rt(side, 1'b0);
                set_hv(side, 1'b0);
            end
            if (k == drop_at) set_hv(side, 1'b0);
        end
        set_hv(side, 1'b0);
        set_rt(side, 1'b0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int first, last, nd, no, ns, lim, side, sel;
        int f_p, f_s, n_serr;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 outputs after reset", {pri_discard, sec_discard, to_status, serr_req}, 0);
        // R1/R2: default select is long limit
        run_side(0, 0, 0, L_LONG + 4, first, last, nd, no, ns);
        check("R1 default long limit", first, L_LONG + 1);
        check("R1 serr enable off after reset", ns, 0);

        // vector walk: R2 R3 R4 R7 R10
        for (int v = 0; v < 8; v++) begin
            side = VEC[v][13];
            sel  = VEC[v][12];
            lim  = sel ? L_SHRT : L_LONG;
            serr_global_en = VEC[v][10];
            wr_cfg({VEC[v][11], 1'b1, (side == 1) ? VEC[v][12] : 1'b0,
                    (side == 0) ? VEC[v][12] : 1'b0});
            check("R9 clear before vector", to_status, 0);
            run_side(side, int'(VEC[v][9:2]), 0, lim + 4, first, last, nd, no, ns);
            check(sel ? "R3 discard count" : "R2 discard count", nd, VEC[v][1] ? 2 - 1 : 0);
            if (VEC[v][1])
                check(sel ? "R3 discard timing" : "R2 discard timing", first, lim + 1);
            else
                check("R4 retry cancels", nd, 0);
            check("R7 other side quiet", no, 0);
            check("R10 serr pulses", ns, int'(VEC[v][0]));
            check("R8 flag after vector", to_status, int'(VEC[v][1]));
        end

        // R9: write-1 clears the flag
        wr_cfg(4'b0100);
        check("R9 w1c clears", to_status, 0);

        // R5: head-valid drop mid count
        wr_cfg(4'b0001);
        run_side(0, 0, 8, L_SHRT + 8, first, last, nd, no, ns);
        check("R5 drop abandons", nd, 0);
        check("R5 flag untouched", to_status, 0);

        // R6: held head-valid restarts after discard
        run_side(0, 0, 0, 2 * L_SHRT + 4, first, last, nd, no, ns);
        check("R6 two strobes", nd, 2);
        check("R6 one-cycle strobe first", first, L_SHRT + 1);
        check("R6 reload second", last, 2 * L_SHRT + 2);

        // R7/R10: sides with different selects at once
        serr_global_en = 1'b1;
        wr_cfg(4'b1101);
        f_p = 0; f_s = 0; n_serr = 0;
        @(negedge clk);
        pri_head_valid = 1'b1; sec_head_valid = 1'b1;
        for (int k = 1; k <= L_LONG + 3; k++) begin
            @(negedge clk);
            if (pri_discard && f_p == 0) f_p = k;
            if (sec_discard && f_s == 0) f_s = k;
            if (serr_req) n_serr++;
            if (k == L_SHRT + 1) pri_head_valid = 1'b0;
        end
        sec_head_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 primary short", f_p, L_SHRT + 1);
        check("R7 secondary long", f_s, L_LONG + 1);
        check("R10 serr per discard", n_serr, 2);

        // R9: set and clear on the same edge, set wins
        wr_cfg(4'b0101);
        check("R9 cleared before race", to_status, 0);
        @(negedge clk);
        pri_head_valid = 1'b1;
        repeat (L_SHRT + 1) @(negedge clk);
        check("R9 strobe in race cycle", pri_discard, 1);
        pri_head_valid = 1'b0;
        cfg_wr_en = 1'b1; cfg_wr_data = 4'b0101;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_data = '0;
        check("R9 set wins over clear", to_status, 1);
        repeat (3) @(negedge clk);
        check("R8 flag stays set", to_status, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule